// File: doc/BRIEF.md
# Multi-Level Page-Table Walker

This block turns a 64-bit virtual address into a real address by walking translation tables held in memory. A request carries the virtual address, the access kind (read, write or instruction fetch) and the address-space mode. The block picks one of three root descriptors from the mode, checks that the address fits the range the root allows, and then reads one 8-byte entry per level over a simple request/valid memory port. The walk covers up to four region and segment levels plus a final page level.

The result is the real address, a read/write/execute permission triple, a fault code and a translation-exception word. Real addresses in the lowest 8 KiB are relocated by a prefix value. A successful result that lands inside memory also reports storage-key reference and change updates for its page frame. The block handles one walk at a time. It has no translation cache; the caller keeps any cache of recent translations.

Top module: `xlat_walker`

## Requirements
- R1: With `dat_en` low, no table is read, the result has all three permissions and no fault, `done` rises on the second clock edge after the request is accepted, and the real address is the virtual address with bits 11:0 cleared. When `mode64` is low, bits 63:31 are also cleared first, and this masking applies whether or not `dat_en` is set.
- R2: Mode encoding: 0 primary, 2 secondary, 3 home, and 1 is treated as primary. Primary uses `root_pri`, home uses `root_home`, a secondary data access uses `root_sec`, and a secondary fetch (kind 2) uses `root_pri`. Access kind encoding: 0 read, 1 write, 2 fetch.
- R3: Bits 3:2 of the root give its type: 3 first region, 2 second region, 1 third region, 0 segment. A type-2 root with any of bits 63:53 set, a type-1 root with any of bits 63:42 set, or a type-0 root with any of bits 63:31 set gives fault code 3 (specification) and reads no table.
- R4: The first read is at the root origin (root bits 63:12) plus 8 times the index of the root's level. The indexes are bits 63:53 (type 3), 52:42 (type 2), 41:31 (type 1) and 30:20 (segment). The page index is bits 19:12. A root of type 3 therefore needs 5 reads. Region entries give the next table origin in bits 63:12, and segment entries give the page-table origin in bits 63:11.
- R5: Bit 5 set in the root, a region entry or a segment entry gives fault code 1 (segment). Bit 10 set in a page entry gives fault code 2 (page).
- R6: A region or segment entry whose bits 3:2 differ from the level it leads to (next lower level, segment entries 0) gives fault code 3.
- R7: A root with bit 4 set and bit 5 clear maps the address directly (real address equals the aligned virtual address) without any table read.
- R8: Bit 9 set in the page entry removes write permission. A write without write permission gives fault code 4 (protection).
- R9: For secondary mode, fetch results keep only execute permission and data results keep only read and write permission.
- R10: On a fault, the exception word is the aligned virtual address ORed with the mode code (1 primary or secondary fetch, 2 secondary data, 3 home), plus 4 for a protection fault. On success the word, and on a fault the real address and permissions, are zero.
- R11: A real address below 0x2000 has `prefix` added to it.
- R12: On success with a final real address below `MEM_SIZE`, `key_ref` equals read permission, `key_chg` equals write permission and `key_frame` is the real address shifted right by 12. Otherwise all three are zero.
- R13: `req_ready` is high only when idle. Each `mem_req` is a one-cycle pulse, and the next one follows only after `mem_valid`. `done` is a one-cycle pulse carrying all results. Fault codes: 0 none, 1 segment, 2 page, 3 specification, 4 protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode |
| dat_en | input | 1 | Translation enabled |
| mode64 | input | 1 | 64-bit addressing (low: 31-bit) |
| root_pri | input | 64 | Primary root descriptor |
| root_sec | input | 64 | Secondary root descriptor |
| root_home | input | 64 | Home root descriptor |
| prefix | input | 64 | Low-address relocation value |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 64 | Table entry byte address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table entry |
| done | output | 1 | Result valid |
| fault | output | 3 | Fault code |
| real_addr | output | 64 | Final real address |
| perm | output | 3 | {read, write, execute} |
| xword | output | 64 | Translation-exception word |
| key_ref | output | 1 | Set reference key bit |
| key_chg | output | 1 | Set change key bit |
| key_frame | output | 52 | Page frame for the key update |

## Verification
When translation is off, `done` comes exactly two edges after acceptance: one edge into the result state and one that registers the outputs. For walks, each level adds the memory model's one-cycle response plus one edge to issue the next read. The bench does not predict walk latency. It samples on falling edges until `done` appears, takes every result in that same cycle, and counts table reads between acceptance and `done`. It then checks `done` is low one cycle later and that `req_ready` stayed low during the walk.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SEG  = 3'd1,
    FLT_PAGE = 3'd2,
    FLT_SPEC = 3'd3,
    FLT_PROT = 3'd4
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DONE
  } st_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] SPC_SEC  = 2'd2;
  localparam logic [1:0] SPC_HOME = 2'd3;

  // descriptor bit positions
  localparam int D_INV    = 5;
  localparam int D_REAL   = 4;
  localparam int D_TYPE   = 2;
  localparam int PTE_INV  = 10;
  localparam int PTE_RO   = 9;
endpackage

// File: rtl/xlat_root_sel.sv
module xlat_root_sel
  import xlat_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int PX_W       = 8,
  parameter int IX_W       = 11,
  parameter int LEVELS     = 4
) (
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      kind,
  input  logic [1:0]      mode,
  input  logic [VA_W-1:0] root_pri,
  input  logic [VA_W-1:0] root_sec,
  input  logic [VA_W-1:0] root_home,
  output logic [VA_W-1:0] root,
  output logic [1:0]      code,
  output logic [2:0]      pmask,
  output logic            range_bad
);
  localparam int TW = $clog2(LEVELS);
  localparam int LO = PAGE_SHIFT + PX_W + IX_W;

  logic [LEVELS-1:0] too_big;
  logic              is_fetch;
  logic              unused_lo;

  assign unused_lo = ^va[LO-1:0];
  assign is_fetch  = (kind == ACC_FETCH);

  // per root type: bits above the reach of that root must be clear
  for (genvar t = 0; t < LEVELS; t++) begin : g_reach
    localparam int LIM = PAGE_SHIFT + PX_W + (t + 1) * IX_W;
    if (LIM >= VA_W) begin : g_full
      assign too_big[t] = 1'b0;
    end else begin : g_part
      assign too_big[t] = |va[VA_W-1:LIM];
    end
  end

  always_comb begin
    root  = root_pri;
    code  = 2'd1;
    pmask = 3'b111;
    if (mode == SPC_HOME) begin
      root = root_home;
      code = 2'd3;
    end else if (mode == SPC_SEC) begin
      if (is_fetch) begin
        pmask = 3'b001;
      end else begin
        root  = root_sec;
        code  = 2'd2;
        pmask = 3'b110;
      end
    end
  end

  assign range_bad = too_big[root[D_TYPE +: TW]];
endmodule

// File: rtl/xlat_entry_addr.sv
module xlat_entry_addr #(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int PX_W       = 8,
  parameter int IX_W       = 11,
  parameter int LEVELS     = 4
) (
  input  logic [VA_W-1:0]            origin,
  input  logic [VA_W-1:0]            va,
  input  logic [$clog2(LEVELS)-1:0]  lvl,
  input  logic                       is_page,
  output logic [VA_W-1:0]            addr
);
  logic [IX_W-1:0] idx_arr [LEVELS];
  logic            unused_lo;

  assign unused_lo = ^va[PAGE_SHIFT-1:0];

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx_arr[l] = va[PAGE_SHIFT + PX_W + l * IX_W +: IX_W];
  end

  always_comb begin
    if (is_page)
      addr = origin + VA_W'({va[PAGE_SHIFT +: PX_W], 3'b000});
    else
      addr = origin + VA_W'({idx_arr[lvl], 3'b000});
  end
endmodule

// File: rtl/xlat_finish.sv
module xlat_finish #(
  parameter int          VA_W       = 64,
  parameter int          PAGE_SHIFT = 12,
  parameter logic [63:0] LOW_LIMIT  = 64'h2000,
  parameter logic [63:0] MEM_SIZE   = 64'h0100_0000
) (
  input  logic [VA_W-1:0]            raw,
  input  logic [2:0]                 perm_in,
  input  logic                       ok,
  input  logic [VA_W-1:0]            prefix,
  output logic [VA_W-1:0]            real_o,
  output logic                       key_ref,
  output logic                       key_chg,
  output logic [VA_W-PAGE_SHIFT-1:0] key_frame
);
  logic hit;
  logic unused_lo;

  assign unused_lo = perm_in[0];
  assign real_o    = (raw < VA_W'(LOW_LIMIT)) ? raw + prefix : raw;
  assign hit       = ok && (real_o < VA_W'(MEM_SIZE));
  assign key_ref   = hit && perm_in[2];
  assign key_chg   = hit && perm_in[1];
  assign key_frame = hit ? real_o[VA_W-1:PAGE_SHIFT] : '0;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int          VA_W       = 64,
  parameter int          PAGE_SHIFT = 12,
  parameter int          PX_W       = 8,
  parameter int          IX_W       = 11,
  parameter int          LEVELS     = 4,
  parameter logic [63:0] LOW_LIMIT  = 64'h2000,
  parameter logic [63:0] MEM_SIZE   = 64'h0100_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_vaddr,
  input  logic [1:0]                 req_kind,
  input  logic [1:0]                 req_mode,
  input  logic                       dat_en,
  input  logic                       mode64,
  input  logic [VA_W-1:0]            root_pri,
  input  logic [VA_W-1:0]            root_sec,
  input  logic [VA_W-1:0]            root_home,
  input  logic [VA_W-1:0]            prefix,
  output logic                       mem_req,
  output logic [VA_W-1:0]            mem_addr,
  input  logic                       mem_valid,
  input  logic [VA_W-1:0]            mem_rdata,
  output logic                       done,
  output logic [2:0]                 fault,
  output logic [VA_W-1:0]            real_addr,
  output logic [2:0]                 perm,
  output logic [VA_W-1:0]            xword,
  output logic                       key_ref,
  output logic                       key_chg,
  output logic [VA_W-PAGE_SHIFT-1:0] key_frame
);
  localparam int TW     = $clog2(LEVELS);
  localparam int SEG_AL = PX_W + 3;
  localparam int FR_W   = VA_W - PAGE_SHIFT;

  st_e               state;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        kind_q;
  logic [1:0]        code_q;
  logic [2:0]        pmask_q;
  logic [TW-1:0]     lvl_q;
  logic              page_q;
  logic              wr_q;
  logic [VA_W-1:0]   real_q;
  flt_e              res_q;

  // request side
  logic [VA_W-1:0]   va_m, va_eff;
  logic [VA_W-1:0]   root;
  logic [1:0]        code;
  logic [2:0]        pmask;
  logic              range_bad;
  logic [TW-1:0]     rtype;
  logic              unused_bits;

  assign req_ready = (state == ST_IDLE);
  assign va_m      = mode64 ? req_vaddr : {{(VA_W-31){1'b0}}, req_vaddr[30:0]};
  assign va_eff    = {va_m[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign rtype     = root[D_TYPE +: TW];
  assign unused_bits = ^{req_vaddr[PAGE_SHIFT-1:0], root[PAGE_SHIFT-1:0], mem_rdata[SEG_AL-1:0]};

  xlat_root_sel #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PX_W(PX_W), .IX_W(IX_W), .LEVELS(LEVELS)
  ) u_root (
    .va(va_eff), .kind(req_kind), .mode(req_mode),
    .root_pri(root_pri), .root_sec(root_sec), .root_home(root_home),
    .root(root), .code(code), .pmask(pmask), .range_bad(range_bad)
  );

  // next-read selection: from the root when idle, from the entry while walking
  logic [VA_W-1:0] nx_origin, nx_va, nx_addr;
  logic [TW-1:0]   nx_lvl, exp_type;
  logic            nx_page;

  assign exp_type = (lvl_q == '0) ? '0 : lvl_q - TW'(1);

  always_comb begin
    if (state == ST_IDLE) begin
      nx_origin = {root[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
      nx_va     = va_eff;
      nx_lvl    = rtype;
      nx_page   = 1'b0;
    end else begin
      nx_va     = va_q;
      nx_lvl    = exp_type;
      nx_page   = (lvl_q == '0);
      nx_origin = (lvl_q == '0) ? {mem_rdata[VA_W-1:SEG_AL], {SEG_AL{1'b0}}}
                                : {mem_rdata[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
  end

  xlat_entry_addr #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .PX_W(PX_W), .IX_W(IX_W), .LEVELS(LEVELS)
  ) u_eaddr (
    .origin(nx_origin), .va(nx_va), .lvl(nx_lvl), .is_page(nx_page), .addr(nx_addr)
  );

  // result side
  logic            prot;
  flt_e            fin_fault;
  logic            ok;
  logic [2:0]      perm_c;
  logic [VA_W-1:0] fin_real;
  logic            fin_ref, fin_chg;
  logic [FR_W-1:0] fin_frame;

  assign perm_c    = {1'b1, wr_q, 1'b1} & pmask_q;
  assign prot      = (res_q == FLT_NONE) && (kind_q == ACC_WRITE) && !wr_q;
  assign fin_fault = prot ? FLT_PROT : res_q;
  assign ok        = (fin_fault == FLT_NONE);

  xlat_finish #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .LOW_LIMIT(LOW_LIMIT), .MEM_SIZE(MEM_SIZE)
  ) u_fin (
    .raw(real_q), .perm_in(perm_c), .ok(ok), .prefix(prefix),
    .real_o(fin_real), .key_ref(fin_ref), .key_chg(fin_chg), .key_frame(fin_frame)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      kind_q    <= '0;
      code_q    <= '0;
      pmask_q   <= '0;
      lvl_q     <= '0;
      page_q    <= 1'b0;
      wr_q      <= 1'b0;
      real_q    <= '0;
      res_q     <= FLT_NONE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      fault     <= 3'd0;
      real_addr <= '0;
      perm      <= '0;
      xword     <= '0;
      key_ref   <= 1'b0;
      key_chg   <= 1'b0;
      key_frame <= '0;
    end else begin
      mem_req <= 1'b0;
      done    <= 1'b0;
      key_ref <= 1'b0;
      key_chg <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= va_eff;
            kind_q <= req_kind;
            code_q <= code;
            wr_q   <= 1'b1;
            res_q  <= FLT_NONE;
            real_q <= '0;
            if (!dat_en) begin
              pmask_q <= 3'b111;
              real_q  <= va_eff;
              state   <= ST_DONE;
            end else begin
              pmask_q <= pmask;
              if (range_bad) begin
                res_q <= FLT_SPEC;
                state <= ST_DONE;
              end else if (root[D_INV]) begin
                res_q <= FLT_SEG;
                state <= ST_DONE;
              end else if (root[D_REAL]) begin
                real_q <= va_eff;
                state  <= ST_DONE;
              end else begin
                lvl_q    <= rtype;
                page_q   <= 1'b0;
                mem_req  <= 1'b1;
                mem_addr <= nx_addr;
                state    <= ST_WAIT;
              end
            end
          end
        end
        ST_WAIT: begin
          if (mem_valid) begin
            if (page_q) begin
              if (mem_rdata[PTE_INV]) begin
                res_q <= FLT_PAGE;
              end else begin
                real_q <= {mem_rdata[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                wr_q   <= !mem_rdata[PTE_RO];
              end
              state <= ST_DONE;
            end else if (mem_rdata[D_INV]) begin
              res_q <= FLT_SEG;
              state <= ST_DONE;
            end else if (mem_rdata[D_TYPE +: TW] != exp_type) begin
              res_q <= FLT_SPEC;
              state <= ST_DONE;
            end else begin
              lvl_q    <= exp_type;
              page_q   <= (lvl_q == '0);
              mem_req  <= 1'b1;
              mem_addr <= nx_addr;
            end
          end
        end
        ST_DONE: begin
          done      <= 1'b1;
          fault     <= fin_fault;
          real_addr <= ok ? fin_real : '0;
          perm      <= ok ? perm_c : 3'b000;
          xword     <= ok ? '0 : (va_q | VA_W'(code_q) | (prot ? VA_W'(4) : '0));
          key_ref   <= fin_ref;
          key_chg   <= fin_chg;
          key_frame <= fin_frame;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: done and table reads are single-cycle pulses, none while idle
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_req_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  assert_busy_not_ready_R13: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
  // R1: untranslated requests never touch memory
  assert_dat_off_noread_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !dat_en) |=> !mem_req);
  // R8 / R10: a protection fault always marks the exception word
  assert_prot_word_R8: assert property (@(posedge clk) disable iff (rst)
    (done && fault == 3'd4) |-> (xword[2] && perm == 3'b000));
  // R12: key updates only accompany a successful result
  assert_key_success_R12: assert property (@(posedge clk) disable iff (rst)
    (key_ref || key_chg) |-> (done && fault == 3'd0));
endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  localparam logic [63:0] PFX  = 64'h0008_0000;
  localparam logic [63:0] MSZ  = 64'h0100_0000;

  typedef struct packed {
    logic [63:0] va;
    logic [1:0]  kind;
    logic [1:0]  mode;
    logic        dat;
    logic        m64;
    logic [1:0]  rt;
    logic        ro;
    logic [63:0] frame;
    logic [2:0]  xf;
    logic [63:0] xr;
    logic [2:0]  xp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{64'h0000_1234_5678_9ABC, 2'd0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 64'h0,        3'd0, 64'h0000_1234_5678_9000, 3'd7},
    '{64'hFFFF_FFFF_8000_5123, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 64'h0,        3'd0, 64'h0000_0000_0000_5000, 3'd7},
    '{64'h0000_0000_0000_1FFF, 2'd1, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 64'h0,        3'd0, 64'h0000_0000_0008_1000, 3'd7},
    '{64'h0000_0000_1234_5000, 2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 64'h40_0000,  3'd0, 64'h0000_0000_0040_0000, 3'd7},
    '{64'h0000_0000_1234_5000, 2'd1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 64'h40_0000,  3'd4, 64'h0,                   3'd0},
    '{64'h0000_0000_1234_5000, 2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 64'h40_0000,  3'd0, 64'h0000_0000_0040_0000, 3'd5},
    '{64'h0000_0000_1234_5000, 2'd0, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 64'h40_0000,  3'd0, 64'h0000_0000_0041_0000, 3'd6},
    '{64'h0000_0000_1234_5000, 2'd2, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 64'h40_0000,  3'd0, 64'h0000_0000_0040_0000, 3'd1},
    '{64'h0000_0000_1234_5000, 2'd1, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0, 64'h40_0000,  3'd0, 64'h0000_0000_0042_0000, 3'd7},
    '{64'h0123_4567_89AB_C000, 2'd0, 2'd0, 1'b1, 1'b1, 2'd3, 1'b0, 64'h60_0000,  3'd0, 64'h0000_0000_0060_0000, 3'd7},
    '{64'h0020_0000_0000_0000, 2'd0, 2'd0, 1'b1, 1'b1, 2'd2, 1'b0, 64'h60_0000,  3'd3, 64'h0,                   3'd0},
    '{64'h0000_0400_0000_0000, 2'd1, 2'd2, 1'b1, 1'b1, 2'd1, 1'b0, 64'h60_0000,  3'd3, 64'h0,                   3'd0},
    '{64'h0000_0000_8000_0000, 2'd0, 2'd3, 1'b1, 1'b1, 2'd0, 1'b0, 64'h60_0000,  3'd3, 64'h0,                   3'd0},
    '{64'h0000_03AB_CDEF_0000, 2'd1, 2'd0, 1'b1, 1'b1, 2'd1, 1'b0, 64'h70_0000,  3'd0, 64'h0000_0000_0070_0000, 3'd7},
    '{64'hFFFF_FFFF_9234_5000, 2'd0, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 64'h40_0000,  3'd0, 64'h0000_0000_0040_0000, 3'd7},
    '{64'h0000_0000_1234_5000, 2'd0, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 64'h1000,     3'd0, 64'h0000_0000_0008_1000, 3'd7},
    '{64'h0000_0000_1234_5000, 2'd0, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 64'h40_0000,  3'd0, 64'h0000_0000_0040_0000, 3'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic [1:0]  req_mode = '0;
  logic        dat_en = 1'b0;
  logic        mode64 = 1'b1;
  logic [63:0] root_pri = '0, root_sec = '0, root_home = '0;
  logic [63:0] prefix = PFX;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic [2:0]  fault;
  logic [63:0] real_addr;
  logic [2:0]  perm;
  logic [63:0] xword;
  logic        key_ref, key_chg;
  logic [51:0] key_frame;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_mode(req_mode),
    .dat_en(dat_en), .mode64(mode64), .root_pri(root_pri), .root_sec(root_sec),
    .root_home(root_home), .prefix(prefix), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .real_addr(real_addr), .perm(perm), .xword(xword), .key_ref(key_ref),
    .key_chg(key_chg), .key_frame(key_frame)
  );

  // sparse table memory, one-cycle read response
  logic [63:0] mem [logic [63:0]];
  int          rd_total = 0;
  logic [63:0] rd_log [8];

  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req) begin
      mem_valid <= 1'b1;
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
      rd_log[rd_total % 8] <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  function automatic logic [63:0] org(input logic [63:0] base, input int l);
    return base + 64'h10000 * 64'(l + 1);
  endfunction

  function automatic logic [63:0] idx(input logic [63:0] va, input int l);
    if (l < 4) return (va >> (20 + 11 * l)) & 64'h7FF;
    return (va >> 12) & 64'hFF;
  endfunction

  task automatic chain(input logic [63:0] base, input logic [63:0] va, input int rt,
                       input logic [63:0] frame, input logic ro);
    for (int l = rt; l >= 1; l--)
      mem[org(base, l) + idx(va, l) * 8] = org(base, l - 1) | (64'(l - 1) << 2);
    mem[org(base, 0) + idx(va, 0) * 8] = org(base, 4);
    mem[org(base, 4) + idx(va, 4) * 8] = frame | (64'(ro) << 9);
  endtask

  task automatic build(input logic [63:0] va, input logic [1:0] rt,
                       input logic [63:0] frame, input logic ro);
    mem.delete();
    for (int b = 0; b < 3; b++)
      chain(64'(b) * 64'h10_0000, va, int'(rt), frame + 64'(b) * 64'h1_0000, ro);
    root_pri  = org(64'h0, int'(rt))        | (64'(rt) << 2);
    root_sec  = org(64'h10_0000, int'(rt))  | (64'(rt) << 2);
    root_home = org(64'h20_0000, int'(rt))  | (64'(rt) << 2);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // captured results of the last walk
  int          w_cyc, w_reads, w_busy_ready;
  logic [63:0] w_first;
  logic [2:0]  o_fault, o_perm;
  logic [63:0] o_real, o_xword;
  logic        o_ref, o_chg, o_after;
  logic [51:0] o_frame;

  task automatic walk(input logic [63:0] va, input logic [1:0] kind, input logic [1:0] mode,
                      input logic dat, input logic m64);
    int mark;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_mode = mode; dat_en = dat; mode64 = m64;
    req_valid = 1'b1;
    mark = rd_total;
    @(negedge clk);
    req_valid = 1'b0;
    w_cyc = 1;
    w_busy_ready = 0;
    while (!done && w_cyc < 200) begin
      if (req_ready) w_busy_ready++;
      @(negedge clk);
      w_cyc++;
    end
    o_fault = fault; o_perm = perm; o_real = real_addr; o_xword = xword;
    o_ref = key_ref; o_chg = key_chg; o_frame = key_frame;
    w_reads = rd_total - mark;
    w_first = rd_log[mark % 8];
    @(negedge clk);
    o_after = done;
    chk("R13 walk finished", 64'(w_cyc < 200), 64'd1);
    chk("R13 done one cycle", 64'(o_after), 64'd0);
    chk("R13 ready low while busy", 64'(w_busy_ready), 64'd0);
  endtask

  function automatic logic [63:0] mcode(input logic [1:0] mode, input logic [1:0] kind);
    if (mode == 2'd3) return 64'd3;
    if (mode == 2'd2 && kind != 2'd2) return 64'd2;
    return 64'd1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] vb, xw;
    logic        hit;
    string       tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("R13 reset ready", 64'(req_ready), 64'd1);
    chk("R13 reset done", 64'(done), 64'd0);
    chk("R13 reset mem_req", 64'(mem_req), 64'd0);
    chk("R13 reset fault", 64'(fault), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vb = VEC[i].m64 ? VEC[i].va : (VEC[i].va & 64'h7FFF_FFFF);
      build(vb, VEC[i].rt, VEC[i].frame, VEC[i].ro);
      walk(VEC[i].va, VEC[i].kind, VEC[i].mode, VEC[i].dat, VEC[i].m64);
      if (!VEC[i].dat) tag = "R1";
      else if (VEC[i].xf == 3'd3) tag = "R3";
      else if (VEC[i].xf == 3'd4) tag = "R8";
      else if (VEC[i].xf == 3'd0 && VEC[i].xr >= PFX && VEC[i].xr < PFX + 64'h2000) tag = "R11";
      else if (VEC[i].mode == 2'd2) tag = "R9";
      else tag = "R2";
      $display("vector %0d (%s)", i, tag);
      chk({tag, " fault"}, 64'(o_fault), 64'(VEC[i].xf));
      chk({tag, " real"}, o_real, VEC[i].xr);
      chk({tag, " perm"}, 64'(o_perm), 64'(VEC[i].xp));
      xw = (VEC[i].xf != 3'd0)
           ? ((vb & ~64'hFFF) | mcode(VEC[i].mode, VEC[i].kind) | (VEC[i].xf == 3'd4 ? 64'd4 : 64'd0))
           : 64'd0;
      chk("R10 exception word", o_xword, xw);
      hit = (VEC[i].xf == 3'd0) && (VEC[i].xr < MSZ);
      chk("R12 key ref", 64'(o_ref), 64'(hit & VEC[i].xp[2]));
      chk("R12 key chg", 64'(o_chg), 64'(hit & VEC[i].xp[1]));
      chk("R12 key frame", 64'(o_frame), hit ? (VEC[i].xr >> 12) : 64'd0);
      if (!VEC[i].dat) begin
        chk("R1 latency", 64'(w_cyc), 64'd2);
        chk("R1 no reads", 64'(w_reads), 64'd0);
      end
      if (VEC[i].xf == 3'd3) chk("R3 no reads on range fault", 64'(w_reads), 64'd0);
    end

    // R4: full five-level walk, first read address and read count
    vb = 64'h0123_4567_89AB_C000;
    build(vb, 2'd3, 64'h60_0000, 1'b0);
    walk(vb, 2'd0, 2'd0, 1'b1, 1'b1);
    chk("R4 read count", 64'(w_reads), 64'd5);
    chk("R4 first entry address", w_first, org(64'h0, 3) + idx(vb, 3) * 8);

    // R5: invalid page entry
    vb = 64'h0000_0000_1234_5000;
    build(vb, 2'd0, 64'h40_0000, 1'b0);
    mem[org(64'h0, 4) + idx(vb, 4) * 8] = mem[org(64'h0, 4) + idx(vb, 4) * 8] | (64'd1 << 10);
    walk(vb, 2'd0, 2'd0, 1'b1, 1'b1);
    chk("R5 page invalid fault", 64'(o_fault), 64'd2);
    chk("R5 page invalid word", o_xword, vb | 64'd1);

    // R5: invalid segment entry
    build(vb, 2'd0, 64'h40_0000, 1'b0);
    mem[org(64'h0, 0) + idx(vb, 0) * 8] = mem[org(64'h0, 0) + idx(vb, 0) * 8] | (64'd1 << 5);
    walk(vb, 2'd0, 2'd3 - 2'd3, 1'b1, 1'b1);
    chk("R5 segment invalid fault", 64'(o_fault), 64'd1);
    chk("R5 segment invalid reads", 64'(w_reads), 64'd1);

    // R5: invalid root
    build(vb, 2'd0, 64'h40_0000, 1'b0);
    root_home = root_home | (64'd1 << 5);
    walk(vb, 2'd0, 2'd3, 1'b1, 1'b1);
    chk("R5 root invalid fault", 64'(o_fault), 64'd1);
    chk("R5 root invalid word", o_xword, vb | 64'd3);
    chk("R5 root invalid reads", 64'(w_reads), 64'd0);

    // R6: region entry with wrong type
    vb = 64'h0123_4567_89AB_C000;
    build(vb, 2'd3, 64'h60_0000, 1'b0);
    mem[org(64'h0, 3) + idx(vb, 3) * 8] = org(64'h0, 2);
    walk(vb, 2'd0, 2'd0, 1'b1, 1'b1);
    chk("R6 type mismatch fault", 64'(o_fault), 64'd3);
    chk("R6 type mismatch reads", 64'(w_reads), 64'd1);

    // R7: real-space root
    vb = 64'h0000_0000_1234_5000;
    build(vb, 2'd0, 64'h40_0000, 1'b0);
    root_pri = 64'h0000_0000_0001_0000 | (64'd1 << 4);
    walk(vb | 64'h0ABC, 2'd1, 2'd0, 1'b1, 1'b1);
    chk("R7 real-space fault", 64'(o_fault), 64'd0);
    chk("R7 real-space address", o_real, vb);
    chk("R7 real-space reads", 64'(w_reads), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule